// File: doc/BRIEF.md
# Power-Management Event and Timer Block

This block holds the event logic of a system power-management function. A free-running counter advances on each timer-rate enable pulse and can be read as a 32-bit value. Event status, event enable and control registers sit on a small register bus addressed by a 6-bit offset. The block drives a level interrupt toward the operating system whenever an enabled event is pending. Events come from a power-button input and from the counter crossing a half-range boundary.

A write to the control register with the sleep-enable bit set starts a system power action. Sleep type 0 issues a one-cycle power-off request. Sleep type 1 marks a wake event and issues a one-cycle system reset request. A pair of byte ports carries legacy power-management commands. Two command codes switch interrupt routing to the operating system on or off. When a configuration input allows it, any command write also raises a one-cycle system-management interrupt request.

Top module: `pm_event_block`

## Requirements
- R1: The timer counts up by one on each cycle with `tmrTick` high and wraps at 2^TMR_W. A read at offset 0x08 returns the count zero-extended to 32 bits.
- R2: Status is read at offset 0x00, enable at 0x02 and control at 0x04, each in bits 15:0. Every other offset reads as zero.
- R3: A write to status clears each bit written as 1. Bits written as 0 keep their value.
- R4: `sciLevel` is high exactly when status AND enable has any of bits 10, 8, 5 or 0 set.
- R5: Status bit 0 sets on the tick that moves the count onto a multiple of 2^OVF_SHIFT, including the wrap to zero. It stays set until cleared. A set on the same edge as a clear wins.
- R6: Control bit 13 is never stored. A control write with bit 13 set and bits 12:10 equal to 0 gives a one-cycle `powerOffReq`.
- R7: With bit 13 set and bits 12:10 equal to 1, a control write sets status bits 15 and 8 and gives a one-cycle `sysResetReq`. Any other sleep type gives no pulse and no status change.
- R8: A `pwrBtnEvt` pulse sets status bit 8 only while enable bit 8 is 1.
- R9: Writing 0xF1 to the command port (`apmSel`=0) sets control bit 0. Writing 0xF0 clears it. The last command byte reads back on `apmRdata`.
- R10: A command-port write gives a one-cycle `smiReq` when `smiEnCfg` is 1, and no pulse when it is 0.
- R11: The status port (`apmSel`=1) is a plain byte register with no side effects.
- R12: Reset clears the timer, status, enable, control and both byte ports, and holds all request outputs low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tmrTick | input | 1 | Timer-rate clock enable |
| busWr | input | 1 | Register write strobe |
| busAddr | input | 6 | Register offset |
| busWdata | input | 16 | Register write data |
| busRdata | output | 32 | Register read data (combinational) |
| apmWr | input | 1 | Byte-port write strobe |
| apmSel | input | 1 | 0 = command port, 1 = status port |
| apmWdata | input | 8 | Byte-port write data |
| apmRdata | output | 8 | Selected byte-port contents |
| smiEnCfg | input | 1 | Allows system-management interrupt requests |
| pwrBtnEvt | input | 1 | Power-button event pulse |
| sciLevel | output | 1 | Level interrupt to the operating system |
| powerOffReq | output | 1 | Soft power-off request pulse |
| sysResetReq | output | 1 | Suspend-resume reset request pulse |
| smiReq | output | 1 | System-management interrupt request pulse |

## Verification
The bench builds the block with TMR_W=8 and OVF_SHIFT=7. This shrinks the overflow boundary to 128 ticks and the wrap to 256 ticks. With these values, the first boundary crossing and the wrap-to-zero crossing both fall within a short run, and the bench counts every tick itself. The sleep types, the interrupt masking by unlisted status bits and the gating of the management interrupt are each driven directly.

// File: rtl/pm_pkg.sv
package pm_pkg;
  localparam logic [5:0] OFF_STATUS  = 6'h00;
  localparam logic [5:0] OFF_ENABLE  = 6'h02;
  localparam logic [5:0] OFF_CONTROL = 6'h04;
  localparam logic [5:0] OFF_TIMER   = 6'h08;

  localparam int BIT_TMR_OVF  = 0;
  localparam int BIT_PWRBTN   = 8;
  localparam int BIT_WAKE     = 15;
  localparam int BIT_SLP_EN   = 13;
  localparam int BIT_SCI_EN   = 0;

  localparam logic [15:0] SCI_SRC_MASK = 16'h0521;

  localparam logic [7:0] CMD_ACPI_ON  = 8'hF1;
  localparam logic [7:0] CMD_ACPI_OFF = 8'hF0;

  typedef struct packed {
    logic wrStatus;
    logic wrEnable;
    logic wrControl;
    logic sleepResume;
    logic apmCmdWr;
    logic apmStsWr;
    logic acpiOn;
    logic acpiOff;
  } pmStrobe_t;
endpackage

// File: rtl/pm_ctrl.sv
module pm_ctrl
  import pm_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       busWr,
  input  logic [5:0] busAddr,
  input  logic [3:0] sleepField,
  input  logic       apmWr,
  input  logic       apmSel,
  input  logic [7:0] apmWdata,
  input  logic       smiEnCfg,
  output pmStrobe_t  strobe,
  output logic       powerOffReq,
  output logic       sysResetReq,
  output logic       smiReq
);
  logic       sleepReq;
  logic [2:0] sleepType;
  logic       cmdWr;

  assign sleepReq  = sleepField[3];
  assign sleepType = sleepField[2:0];
  assign cmdWr     = apmWr && !apmSel;

  always_comb begin
    strobe             = '0;
    strobe.wrStatus    = busWr && (busAddr == OFF_STATUS);
    strobe.wrEnable    = busWr && (busAddr == OFF_ENABLE);
    strobe.wrControl   = busWr && (busAddr == OFF_CONTROL);
    strobe.sleepResume = strobe.wrControl && sleepReq && (sleepType == 3'd1);
    strobe.apmCmdWr    = cmdWr;
    strobe.apmStsWr    = apmWr && apmSel;
    strobe.acpiOn      = cmdWr && (apmWdata == CMD_ACPI_ON);
    strobe.acpiOff     = cmdWr && (apmWdata == CMD_ACPI_OFF);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      powerOffReq <= 1'b0;
      sysResetReq <= 1'b0;
      smiReq      <= 1'b0;
    end else begin
      powerOffReq <= busWr && (busAddr == OFF_CONTROL) && sleepReq && (sleepType == 3'd0);
      sysResetReq <= strobe.sleepResume;
      smiReq      <= cmdWr && smiEnCfg;
    end
  end
endmodule

// File: rtl/pm_datapath.sv
module pm_datapath
  import pm_pkg::*;
#(
  parameter int TMR_W     = 24,
  parameter int OVF_SHIFT = 23
) (
  input  logic             clk,
  input  logic             rstN,
  input  pmStrobe_t        strobe,
  input  logic             tmrTick,
  input  logic             pwrBtnEvt,
  input  logic [5:0]       busAddr,
  input  logic [15:0]      busWdata,
  input  logic             apmSel,
  input  logic [7:0]       apmWdata,
  output logic [31:0]      busRdata,
  output logic [7:0]       apmRdata,
  output logic             sciLevel,
  output logic [TMR_W-1:0] tmrCount
);
  localparam int LOW_W = OVF_SHIFT;

  logic [15:0] statusQ, enableQ, controlQ;
  logic [15:0] statusSet, statusClr, controlNext;
  logic [7:0]  apmCmdQ, apmStsQ;
  logic        boundaryHit;

  generate
    if (LOW_W == 0) begin : g_every_tick
      assign boundaryHit = tmrTick;
    end else begin : g_low_bits
      assign boundaryHit = tmrTick && (&tmrCount[LOW_W-1:0]);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) tmrCount <= '0;
    else if (tmrTick) tmrCount <= tmrCount + 1'b1;
  end

  always_comb begin
    statusSet = '0;
    statusSet[BIT_TMR_OVF] = boundaryHit;
    statusSet[BIT_PWRBTN]  = (pwrBtnEvt && enableQ[BIT_PWRBTN]) || strobe.sleepResume;
    statusSet[BIT_WAKE]    = strobe.sleepResume;
    statusClr = strobe.wrStatus ? busWdata : 16'h0000;
  end

  always_comb begin
    controlNext = controlQ;
    if (strobe.wrControl) begin
      controlNext = busWdata;
      controlNext[BIT_SLP_EN] = 1'b0;
    end
    if (strobe.acpiOn)  controlNext[BIT_SCI_EN] = 1'b1;
    if (strobe.acpiOff) controlNext[BIT_SCI_EN] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      statusQ  <= '0;
      enableQ  <= '0;
      controlQ <= '0;
      apmCmdQ  <= '0;
      apmStsQ  <= '0;
    end else begin
      statusQ  <= (statusQ & ~statusClr) | statusSet;
      controlQ <= controlNext;
      if (strobe.wrEnable) enableQ <= busWdata;
      if (strobe.apmCmdWr) apmCmdQ <= apmWdata;
      if (strobe.apmStsWr) apmStsQ <= apmWdata;
    end
  end

  always_comb begin
    case (busAddr)
      OFF_STATUS:  busRdata = {16'h0000, statusQ};
      OFF_ENABLE:  busRdata = {16'h0000, enableQ};
      OFF_CONTROL: busRdata = {16'h0000, controlQ};
      OFF_TIMER:   busRdata = 32'(tmrCount);
      default:     busRdata = 32'h0000_0000;
    endcase
  end

  assign apmRdata = apmSel ? apmStsQ : apmCmdQ;
  assign sciLevel = |(statusQ & enableQ & SCI_SRC_MASK);
endmodule

// File: rtl/pm_event_block.sv
module pm_event_block
  import pm_pkg::*;
#(
  parameter int TMR_W     = 24,
  parameter int OVF_SHIFT = 23
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        tmrTick,
  input  logic        busWr,
  input  logic [5:0]  busAddr,
  input  logic [15:0] busWdata,
  output logic [31:0] busRdata,
  input  logic        apmWr,
  input  logic        apmSel,
  input  logic [7:0]  apmWdata,
  output logic [7:0]  apmRdata,
  input  logic        smiEnCfg,
  input  logic        pwrBtnEvt,
  output logic        sciLevel,
  output logic        powerOffReq,
  output logic        sysResetReq,
  output logic        smiReq
);
  pmStrobe_t        strobe;
  logic [TMR_W-1:0] tmrCount;

  pm_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busAddr(busAddr),
    .sleepField(busWdata[13:10]), .apmWr(apmWr), .apmSel(apmSel),
    .apmWdata(apmWdata), .smiEnCfg(smiEnCfg), .strobe(strobe),
    .powerOffReq(powerOffReq), .sysResetReq(sysResetReq), .smiReq(smiReq)
  );

  pm_datapath #(.TMR_W(TMR_W), .OVF_SHIFT(OVF_SHIFT)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .tmrTick(tmrTick),
    .pwrBtnEvt(pwrBtnEvt), .busAddr(busAddr), .busWdata(busWdata),
    .apmSel(apmSel), .apmWdata(apmWdata), .busRdata(busRdata),
    .apmRdata(apmRdata), .sciLevel(sciLevel), .tmrCount(tmrCount)
  );
endmodule

// File: rtl/pm_event_block_checker.sv
module pm_event_block_checker #(
  parameter int TMR_W = 24
) (
  input logic             clk,
  input logic             rstN,
  input logic             tmrTick,
  input logic             busWr,
  input logic [5:0]       busAddr,
  input logic [15:0]      busWdata,
  input logic             apmWr,
  input logic             apmSel,
  input logic             smiEnCfg,
  input logic             powerOffReq,
  input logic             sysResetReq,
  input logic             smiReq,
  input logic [TMR_W-1:0] tmrCount
);
  p_timer_step_r1: assert property (@(posedge clk) disable iff (!rstN)
    tmrTick |=> tmrCount == $past(tmrCount) + 1'b1);
  p_timer_hold_r1: assert property (@(posedge clk) disable iff (!rstN)
    !tmrTick |=> $stable(tmrCount));
  p_off_pulse_r6: assert property (@(posedge clk) disable iff (!rstN)
    powerOffReq |=> !powerOffReq);
  p_off_cause_r6: assert property (@(posedge clk) disable iff (!rstN)
    powerOffReq |-> $past(busWr && busAddr == 6'h04 && busWdata[13:10] == 4'b1000));
  p_reset_pulse_r7: assert property (@(posedge clk) disable iff (!rstN)
    sysResetReq |=> !sysResetReq);
  p_reset_cause_r7: assert property (@(posedge clk) disable iff (!rstN)
    sysResetReq |-> $past(busWr && busAddr == 6'h04 && busWdata[13:10] == 4'b1001));
  p_smi_gate_r10: assert property (@(posedge clk) disable iff (!rstN)
    smiReq |-> $past(apmWr && !apmSel && smiEnCfg));
  p_smi_pulse_r10: assert property (@(posedge clk) disable iff (!rstN)
    $past(apmWr && !apmSel && smiEnCfg) |-> smiReq);
endmodule

bind pm_event_block pm_event_block_checker #(.TMR_W(TMR_W)) u_chk (
  .clk(clk), .rstN(rstN), .tmrTick(tmrTick), .busWr(busWr),
  .busAddr(busAddr), .busWdata(busWdata), .apmWr(apmWr), .apmSel(apmSel),
  .smiEnCfg(smiEnCfg), .powerOffReq(powerOffReq), .sysResetReq(sysResetReq),
  .smiReq(smiReq), .tmrCount(tmrCount)
);

// File: tb/pm_event_block_bench.sv
`timescale 1ns/1ps
module pm_event_block_bench;
  localparam int TMR_W = 8;
  localparam int OVF_SHIFT = 7;

  logic clk = 1'b0, rstN = 1'b0, tmrTick = 1'b0, busWr = 1'b0;
  logic [5:0] busAddr = '0;
  logic [15:0] busWdata = '0;
  logic [31:0] busRdata;
  logic apmWr = 1'b0, apmSel = 1'b0, smiEnCfg = 1'b0, pwrBtnEvt = 1'b0;
  logic [7:0] apmWdata = '0, apmRdata;
  logic sciLevel, powerOffReq, sysResetReq, smiReq;

  int checks = 0, failures = 0, tickCount = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  pm_event_block #(.TMR_W(TMR_W), .OVF_SHIFT(OVF_SHIFT)) u_pm_event_block (
    .clk(clk), .rstN(rstN), .tmrTick(tmrTick), .busWr(busWr),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .apmWr(apmWr), .apmSel(apmSel), .apmWdata(apmWdata), .apmRdata(apmRdata),
    .smiEnCfg(smiEnCfg), .pwrBtnEvt(pwrBtnEvt), .sciLevel(sciLevel),
    .powerOffReq(powerOffReq), .sysResetReq(sysResetReq), .smiReq(smiReq)
  );

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic chk_eq(input string tag, input longint act, input longint exp);
    check(act == exp, tag, act, exp);
  endtask

  task automatic reg_write(input logic [5:0] a, input logic [15:0] d);
    @(negedge clk); busWr = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk); busWr = 1'b0;
  endtask

  task automatic reg_read(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk); busAddr = a; #0.5; d = busRdata;
  endtask

  task automatic apm_write(input logic sel, input logic [7:0] d);
    @(negedge clk); apmWr = 1'b1; apmSel = sel; apmWdata = d;
    @(negedge clk); apmWr = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tmrTick = 1'b1;
    end
    @(negedge clk); tmrTick = 1'b0;
    tickCount = (tickCount + n) % 256;
  endtask

  task automatic do_reset();
    @(negedge clk); rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    tickCount = 0;
  endtask

  task automatic t_reset_state();
    logic [31:0] d;
    reg_read(6'h00, d); chk_eq("R12 status", d, 0);
    reg_read(6'h02, d); chk_eq("R12 enable", d, 0);
    reg_read(6'h04, d); chk_eq("R12 control", d, 0);
    reg_read(6'h08, d); chk_eq("R12 timer", d, 0);
    apmSel = 1'b0; #0.5; chk_eq("R12 apm cmd", apmRdata, 0);
    apmSel = 1'b1; #0.5; chk_eq("R12 apm sts", apmRdata, 0);
    chk_eq("R12 outputs", {sciLevel, powerOffReq, sysResetReq, smiReq}, 0);
  endtask

  task automatic t_map();
    logic [31:0] d;
    ticks(5);
    reg_read(6'h08, d); chk_eq("R1 timer count", d, 5);
    reg_write(6'h02, 16'h1234);
    reg_read(6'h02, d); chk_eq("R2 enable readback", d, 32'h1234);
    reg_read(6'h06, d); chk_eq("R2 unmapped 06", d, 0);
    reg_read(6'h3E, d); chk_eq("R2 unmapped 3E", d, 0);
    reg_write(6'h02, 16'h0000);
  endtask

  task automatic t_overflow();
    logic [31:0] d;
    reg_write(6'h02, 16'h0001);
    ticks(127 - tickCount);
    reg_read(6'h00, d); chk_eq("R5 no set before boundary", d[0], 0);
    chk_eq("R4 sci low", sciLevel, 0);
    ticks(1);
    reg_read(6'h00, d); chk_eq("R5 set at boundary", d[0], 1);
    chk_eq("R4 sci high on overflow", sciLevel, 1);
    reg_write(6'h00, 16'h0001);
    reg_read(6'h00, d); chk_eq("R3 clear by one", d[0], 0);
    chk_eq("R4 sci low after clear", sciLevel, 0);
    ticks(127);
    reg_read(6'h08, d); chk_eq("R1 timer at 255", d, 255);
    reg_read(6'h00, d); chk_eq("R5 no set at 255", d[0], 0);
    ticks(1);
    reg_read(6'h08, d); chk_eq("R1 wrap to zero", d, 0);
    reg_read(6'h00, d); chk_eq("R5 set on wrap", d[0], 1);
    reg_write(6'h00, 16'h0001);
    reg_write(6'h02, 16'h0000);
  endtask

  task automatic t_button();
    logic [31:0] d;
    @(negedge clk); pwrBtnEvt = 1'b1; @(negedge clk); pwrBtnEvt = 1'b0;
    reg_read(6'h00, d); chk_eq("R8 button ignored when disabled", d, 0);
    reg_write(6'h02, 16'h0100);
    @(negedge clk); pwrBtnEvt = 1'b1; @(negedge clk); pwrBtnEvt = 1'b0;
    reg_read(6'h00, d); chk_eq("R8 button sets bit8", d, 32'h0100);
    chk_eq("R4 sci on button", sciLevel, 1);
    reg_write(6'h00, 16'h0000);
    reg_read(6'h00, d); chk_eq("R3 zeros keep", d, 32'h0100);
    reg_write(6'h00, 16'h0100);
    reg_read(6'h00, d); chk_eq("R3 bit8 cleared", d, 0);
  endtask

  task automatic t_sleep();
    logic [31:0] d;
    reg_write(6'h02, 16'h8000);
    reg_write(6'h04, 16'h2005);
    chk_eq("R6 power-off pulse", powerOffReq, 1);
    chk_eq("R7 no reset for type 0", sysResetReq, 0);
    @(negedge clk); chk_eq("R6 pulse one cycle", powerOffReq, 0);
    reg_read(6'h04, d); chk_eq("R6 bit13 not stored", d, 32'h0005);
    reg_write(6'h04, 16'h2400);
    chk_eq("R7 reset pulse", sysResetReq, 1);
    chk_eq("R6 no off for type 1", powerOffReq, 0);
    @(negedge clk); chk_eq("R7 pulse one cycle", sysResetReq, 0);
    reg_read(6'h00, d); chk_eq("R7 wake bits", d, 32'h8100);
    chk_eq("R4 unlisted bit15 masked", sciLevel, 0);
    reg_write(6'h00, 16'hFFFF);
    reg_write(6'h04, 16'h2C00);
    chk_eq("R7 type 3 no pulses", {powerOffReq, sysResetReq}, 0);
    reg_read(6'h00, d); chk_eq("R7 type 3 no status", d, 0);
    reg_read(6'h04, d); chk_eq("R6 type 3 stored", d, 32'h0C00);
    reg_write(6'h04, 16'h0000);
    reg_write(6'h02, 16'h0000);
  endtask

  task automatic t_apm();
    logic [31:0] d;
    smiEnCfg = 1'b0;
    apm_write(1'b0, 8'hF1);
    chk_eq("R10 no smi when disabled", smiReq, 0);
    reg_read(6'h04, d); chk_eq("R9 acpi on", d, 32'h0001);
    apmSel = 1'b0; #0.5; chk_eq("R9 cmd readback", apmRdata, 8'hF1);
    apm_write(1'b0, 8'hF0);
    reg_read(6'h04, d); chk_eq("R9 acpi off", d, 0);
    smiEnCfg = 1'b1;
    apm_write(1'b0, 8'h55);
    chk_eq("R10 smi pulse", smiReq, 1);
    @(negedge clk); chk_eq("R10 smi one cycle", smiReq, 0);
    reg_read(6'h04, d); chk_eq("R9 other cmd no change", d, 0);
    apm_write(1'b1, 8'hA5);
    chk_eq("R11 no smi from status port", smiReq, 0);
    apmSel = 1'b1; #0.5; chk_eq("R11 status readback", apmRdata, 8'hA5);
    apmSel = 1'b0; #0.5; chk_eq("R11 cmd untouched", apmRdata, 8'h55);
    reg_read(6'h04, d); chk_eq("R11 control untouched", d, 0);
    smiEnCfg = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    do_reset();
    t_reset_state();
    t_map();
    t_overflow();
    t_button();
    t_sleep();
    t_apm();
    reg_write(6'h02, 16'hFFFF);
    apm_write(1'b1, 8'h3C);
    ticks(3);
    do_reset();
    t_reset_state();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule